// File: doc/BRIEF.md
# SDRAM Command Timing Checker

This block sits beside an SDRAM controller and watches the command bus every clock: clock enable, chip select, the three strobes, the auto-precharge address bit and the bank address. It never drives anything. From these inputs it decodes each command and tracks whether each bank is open or closed. It measures the spacing between related commands with saturating cycle counters, one set per bank, plus a few global ones. When a command breaks a state rule or a minimum spacing, it reports a single violation one clock later, with a numeric code and the bank involved.

A refresh watchdog counts the cycles since the last auto refresh and raises a violation when the average refresh interval runs out. Time spent in self refresh does not count. A sticky flag and a saturating violation counter summarise a run, and only reset clears them. All spacings are parameters given in clock cycles. The defaults match a 133 MHz part with 4096 refreshes per 64 ms.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: A command is decoded only when clock enable was high in the previous cycle. Chip select high is a deselect. With select low, {ras_n,cas_n,we_n} decode as 111 NOP, 011 activate, 101 read, 100 write, 010 precharge, 110 burst stop and 000 mode-register set. Code 001 is auto refresh when clock enable is still high and self-refresh entry when it has just fallen. Deselects, NOPs and ignored cycles never raise a violation.
- R2: Activate to a bank that is already open raises code 3. Read or write to a closed bank raises code 2.
- R3: Read or write fewer than T_RCD (3) clocks after activate on the same bank raises code 5.
- R4: Activate fewer than T_RP (3) clocks after that bank was precharged, explicitly or by auto-precharge, raises code 6.
- R5: Precharge to an open bank fewer than T_RAS (6) clocks after its activate raises code 7. Precharge with a10 high targets every bank, and a10 low targets the bank on ba. Precharge leaves the targeted banks closed.
- R6: Activate fewer than T_RC (9) clocks after the previous activate on the same bank raises code 8.
- R7: Activate fewer than T_RRD (2) clocks after an activate to any bank raises code 9.
- R8: Any command other than NOP, deselect or an ignored cycle fewer than T_MRD (2) clocks after a mode-register set raises code 1.
- R9: Precharge fewer than T_WR (2) clocks after the last write data raises code 10. With burst length 1, the last data is in the write cycle.
- R10: Auto refresh, self-refresh entry or mode-register set while any bank is open raises code 4, reporting the lowest open bank.
- R11: If no auto refresh or self-refresh entry has come by the time REFI_CYCLES (2083) clocks have elapsed since the last one, code 11 is raised once with bank 0. Cycles in self refresh, up to the first cycle with clock enable high, do not count.
- R12: Read or write with a10 high closes the bank in the first cycle in which its activate is at least T_RAS old and its write recovery has elapsed. Until then the bank stays open.
- R13: A violation appears on the outputs in the cycle after the command, for one cycle. When several rules fail at once, the lowest code is reported. The bank field is the offending bank: the ba field for codes 1 and 9, and 0 for code 11. The sticky flag and the saturating counter start at zero after reset and change only by accumulating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Observed clock enable |
| cs_ni | input | 1 | Observed chip select, active low |
| ras_ni | input | 1 | Observed row strobe, active low |
| cas_ni | input | 1 | Observed column strobe, active low |
| we_ni | input | 1 | Observed write enable, active low |
| a10_i | input | 1 | Observed address bit 10 (all-bank / auto-precharge select) |
| ba_i | input | BA_W | Observed bank address |
| err_valid_o | output | 1 | One-cycle violation strobe |
| err_code_o | output | 4 | Violation code (0 when none) |
| err_bank_o | output | BA_W | Bank tied to the violation |
| err_sticky_o | output | 1 | Set by the first violation, cleared by reset |
| err_count_o | output | CNT_W | Saturating violation count |

## Verification
Each spacing rule is driven one cycle short of its limit and also exactly at the limit. This separates an off-by-one in the counters from a correct comparison. Open/closed tracking is exercised by explicit precharge to one bank, precharge to all banks, and auto-precharge after both read and write. Commands placed just before and just after the computed auto-close cycle show when the bank really closes. Overlapping faults, such as a closed-bank read inside the mode-register window, check the priority of the codes. A refresh gap one cycle over and exactly at the limit, and a self-refresh stay longer than the limit, check the watchdog and its pause.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

    typedef enum logic [3:0] {
        CMD_IGN, CMD_DESEL, CMD_NOP, CMD_ACT, CMD_RD, CMD_WR,
        CMD_PRE, CMD_BST, CMD_REF, CMD_SRE, CMD_MRS
    } cmd_e;

    // lower value = higher report priority
    typedef enum logic [3:0] {
        ERR_NONE      = 4'd0,
        ERR_MRD       = 4'd1,
        ERR_RW_CLOSED = 4'd2,
        ERR_ACT_OPEN  = 4'd3,
        ERR_BANK_OPEN = 4'd4,
        ERR_TRCD      = 4'd5,
        ERR_TRP       = 4'd6,
        ERR_TRAS      = 4'd7,
        ERR_TRC       = 4'd8,
        ERR_TRRD      = 4'd9,
        ERR_TWR       = 4'd10,
        ERR_REFI      = 4'd11
    } err_e;

    function automatic err_e err_pick(input err_e a, input err_e b);
        if (a == ERR_NONE) return b;
        if (b == ERR_NONE) return a;
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_mon_pkg::*;
(
    input  logic cke_prev_i,
    input  logic cke_i,
    input  logic cs_ni,
    input  logic ras_ni,
    input  logic cas_ni,
    input  logic we_ni,
    output cmd_e cmd_o
);

    always_comb begin
        cmd_o = CMD_NOP;
        if (!cke_prev_i) begin
            cmd_o = CMD_IGN;
        end else if (cs_ni) begin
            cmd_o = CMD_DESEL;
        end else begin
            case ({ras_ni, cas_ni, we_ni})
                3'b111: cmd_o = CMD_NOP;
                3'b011: cmd_o = CMD_ACT;
                3'b101: cmd_o = CMD_RD;
                3'b100: cmd_o = CMD_WR;
                3'b010: cmd_o = CMD_PRE;
                3'b110: cmd_o = CMD_BST;
                3'b001: cmd_o = cke_i ? CMD_REF : CMD_SRE;
                3'b000: cmd_o = CMD_MRS;
                default: cmd_o = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
    import sdram_mon_pkg::*;
#(
    parameter int T_RCD  = 3,
    parameter int T_RP   = 3,
    parameter int T_RAS  = 6,
    parameter int T_RC   = 9,
    parameter int WR_REC = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  cmd_e cmd_i,
    input  logic sel_i,
    input  logic a10_i,
    output logic open_o,
    output err_e err_o
);

    localparam int M1      = (T_RCD > T_RP) ? T_RCD : T_RP;
    localparam int M2      = (T_RAS > T_RC) ? T_RAS : T_RC;
    localparam int M3      = (M1 > M2) ? M1 : M2;
    localparam int AGE_MAX = (M3 > WR_REC) ? M3 : WR_REC;
    localparam int AGE_W   = $clog2(AGE_MAX + 1);

    localparam logic [AGE_W-1:0] RCD_L = AGE_W'(T_RCD);
    localparam logic [AGE_W-1:0] RP_L  = AGE_W'(T_RP);
    localparam logic [AGE_W-1:0] RAS_L = AGE_W'(T_RAS);
    localparam logic [AGE_W-1:0] RC_L  = AGE_W'(T_RC);
    localparam logic [AGE_W-1:0] WRR_L = AGE_W'(WR_REC);
    localparam logic [AGE_W-1:0] MAX_L = AGE_W'(AGE_MAX);
    localparam logic [AGE_W-1:0] ONE_L = AGE_W'(1);

    typedef struct packed {
        logic             open;
        logic             ap;
        logic [AGE_W-1:0] act_age;
        logic [AGE_W-1:0] pre_age;
        logic [AGE_W-1:0] wr_age;
    } bank_st_t;

    bank_st_t st_d, st_q;
    err_e     err_d;

    function automatic logic [AGE_W-1:0] sat_inc(input logic [AGE_W-1:0] v);
        return (v >= MAX_L) ? MAX_L : v + ONE_L;
    endfunction

    always_comb begin
        logic pre_hit;
        logic touched;
        st_d         = st_q;
        err_d        = ERR_NONE;
        st_d.act_age = sat_inc(st_q.act_age);
        st_d.pre_age = sat_inc(st_q.pre_age);
        st_d.wr_age  = sat_inc(st_q.wr_age);
        pre_hit      = (cmd_i == CMD_PRE) && (sel_i || a10_i);
        touched      = pre_hit ||
                       (sel_i && (cmd_i == CMD_ACT || cmd_i == CMD_RD || cmd_i == CMD_WR));

        case (cmd_i)
            CMD_ACT: begin
                if (sel_i) begin
                    if (st_q.open)                 err_d = ERR_ACT_OPEN;
                    else if (st_q.pre_age < RP_L)  err_d = ERR_TRP;
                    else if (st_q.act_age < RC_L)  err_d = ERR_TRC;
                    st_d.open    = 1'b1;
                    st_d.ap      = 1'b0;
                    st_d.act_age = ONE_L;
                end
            end
            CMD_RD, CMD_WR: begin
                if (sel_i) begin
                    if (!st_q.open)                err_d = ERR_RW_CLOSED;
                    else if (st_q.act_age < RCD_L) err_d = ERR_TRCD;
                    if (st_q.open) begin
                        st_d.ap = a10_i;
                        if (cmd_i == CMD_WR) st_d.wr_age = ONE_L;
                    end
                end
            end
            CMD_PRE: begin
                if (pre_hit && st_q.open) begin
                    if (st_q.act_age < RAS_L)      err_d = ERR_TRAS;
                    else if (st_q.wr_age < WRR_L)  err_d = ERR_TWR;
                    st_d.open    = 1'b0;
                    st_d.ap      = 1'b0;
                    st_d.pre_age = ONE_L;
                end
            end
            default: ;
        endcase

        // auto-precharge closes once row time and write recovery are both met
        if (!touched && st_q.open && st_q.ap &&
            st_q.act_age >= RAS_L && st_q.wr_age >= WRR_L) begin
            st_d.open    = 1'b0;
            st_d.ap      = 1'b0;
            st_d.pre_age = ONE_L;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.open    <= 1'b0;
            st_q.ap      <= 1'b0;
            st_q.act_age <= MAX_L;
            st_q.pre_age <= MAX_L;
            st_q.wr_age  <= MAX_L;
        end else begin
            st_q <= st_d;
        end
    end

    assign open_o = st_q.open;
    assign err_o  = err_d;

    AST_ACT_OPENS_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_i == CMD_ACT && sel_i) |=> st_q.open); // R2

    AST_PRE_CLOSES_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_i == CMD_PRE && (sel_i || a10_i)) |=> !st_q.open); // R5

    AST_AUTO_CLOSE_AFTER_RAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(st_q.open) && !$past(cmd_i == CMD_PRE)) |-> ($past(st_q.act_age) >= RAS_L)); // R12

endmodule

// File: rtl/sdram_refresh_wdog.sv
module sdram_refresh_wdog
    import sdram_mon_pkg::*;
#(
    parameter int REFI_CYCLES = 2083
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  cmd_e cmd_i,
    input  logic cke_i,
    output logic err_o
);

    localparam int REF_W = $clog2(REFI_CYCLES + 2);
    localparam logic [REF_W-1:0] REF_L = REF_W'(REFI_CYCLES);
    localparam logic [REF_W-1:0] ONE_L = REF_W'(1);

    typedef struct packed {
        logic             self_ref;
        logic [REF_W-1:0] age;
    } wd_st_t;

    wd_st_t st_d, st_q;
    logic   refresh_seen;

    always_comb begin
        refresh_seen = (cmd_i == CMD_REF) || (cmd_i == CMD_SRE);
        st_d         = st_q;
        err_o        = (st_q.age == REF_L) && !st_q.self_ref && !refresh_seen;

        if (cmd_i == CMD_SRE) begin
            st_d.self_ref = 1'b1;
        end else if (st_q.self_ref && cke_i) begin
            st_d.self_ref = 1'b0;
        end

        if (refresh_seen || st_q.self_ref) begin
            st_d.age = ONE_L;
        end else if (st_q.age <= REF_L) begin
            st_d.age = st_q.age + ONE_L;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.self_ref <= 1'b0;
            st_q.age      <= ONE_L;
        end else begin
            st_q <= st_d;
        end
    end

    AST_REFI_SINGLE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |=> !err_o); // R11

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
    import sdram_mon_pkg::*;
#(
    parameter int NUM_BANKS   = 4,
    parameter int T_RCD       = 3,
    parameter int T_RP        = 3,
    parameter int T_RAS       = 6,
    parameter int T_RC        = 9,
    parameter int T_RRD       = 2,
    parameter int T_MRD       = 2,
    parameter int T_WR        = 2,
    parameter int BURST_LEN   = 1,
    parameter int REFI_CYCLES = 2083,
    parameter int CNT_W       = 16,
    localparam int BA_W       = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cke_i,
    input  logic             cs_ni,
    input  logic             ras_ni,
    input  logic             cas_ni,
    input  logic             we_ni,
    input  logic             a10_i,
    input  logic [BA_W-1:0]  ba_i,
    output logic             err_valid_o,
    output logic [3:0]       err_code_o,
    output logic [BA_W-1:0]  err_bank_o,
    output logic             err_sticky_o,
    output logic [CNT_W-1:0] err_count_o
);

    localparam int WR_REC  = BURST_LEN - 1 + T_WR;
    localparam int GAP_MAX = (T_RRD > T_MRD) ? T_RRD : T_MRD;
    localparam int GAP_W   = $clog2(GAP_MAX + 1);
    localparam logic [GAP_W-1:0] GAP_L = GAP_W'(GAP_MAX);
    localparam logic [GAP_W-1:0] RRD_L = GAP_W'(T_RRD);
    localparam logic [GAP_W-1:0] MRD_L = GAP_W'(T_MRD);
    localparam logic [GAP_W-1:0] G1_L  = GAP_W'(1);

    typedef struct packed {
        logic             cke_prev;
        logic [GAP_W-1:0] rrd_age;
        logic [GAP_W-1:0] mrd_age;
        logic             err_valid;
        err_e             err_code;
        logic [BA_W-1:0]  err_bank;
        logic             sticky;
        logic [CNT_W-1:0] count;
    } mon_st_t;

    mon_st_t st_d, st_q;

    cmd_e                 cmd;
    err_e                 bank_err [NUM_BANKS];
    logic [NUM_BANKS-1:0] bank_open;
    logic                 refi_err;

    sdram_cmd_decode u_decode (
        .cke_prev_i (st_q.cke_prev),
        .cke_i      (cke_i),
        .cs_ni      (cs_ni),
        .ras_ni     (ras_ni),
        .cas_ni     (cas_ni),
        .we_ni      (we_ni),
        .cmd_o      (cmd)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        sdram_bank_track #(
            .T_RCD  (T_RCD),
            .T_RP   (T_RP),
            .T_RAS  (T_RAS),
            .T_RC   (T_RC),
            .WR_REC (WR_REC)
        ) u_track (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .cmd_i  (cmd),
            .sel_i  (ba_i == BA_W'(g)),
            .a10_i  (a10_i),
            .open_o (bank_open[g]),
            .err_o  (bank_err[g])
        );
    end

    sdram_refresh_wdog #(
        .REFI_CYCLES (REFI_CYCLES)
    ) u_wdog (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .cmd_i  (cmd),
        .cke_i  (cke_i),
        .err_o  (refi_err)
    );

    always_comb begin
        err_e            pick_err;
        logic [BA_W-1:0] pick_bank;
        logic [BA_W-1:0] open_bank;
        err_e            glob_err;
        err_e            fin_err;
        logic            active_cmd;

        pick_err  = ERR_NONE;
        pick_bank = '0;
        open_bank = '0;
        for (int b = NUM_BANKS - 1; b >= 0; b--) begin
            if (bank_err[b] != ERR_NONE) begin
                pick_err  = bank_err[b];
                pick_bank = BA_W'(b);
            end
            if (bank_open[b]) open_bank = BA_W'(b);
        end

        active_cmd = !(cmd == CMD_IGN || cmd == CMD_DESEL || cmd == CMD_NOP);
        glob_err   = ERR_NONE;
        if (active_cmd && st_q.mrd_age < MRD_L)
            glob_err = err_pick(glob_err, ERR_MRD);
        if ((cmd == CMD_REF || cmd == CMD_SRE || cmd == CMD_MRS) && (|bank_open))
            glob_err = err_pick(glob_err, ERR_BANK_OPEN);
        if (cmd == CMD_ACT && st_q.rrd_age < RRD_L)
            glob_err = err_pick(glob_err, ERR_TRRD);
        if (refi_err)
            glob_err = err_pick(glob_err, ERR_REFI);

        fin_err = err_pick(pick_err, glob_err);

        st_d          = st_q;
        st_d.cke_prev = cke_i;
        st_d.rrd_age  = (st_q.rrd_age >= GAP_L) ? GAP_L : st_q.rrd_age + G1_L;
        st_d.mrd_age  = (st_q.mrd_age >= GAP_L) ? GAP_L : st_q.mrd_age + G1_L;
        if (cmd == CMD_ACT) st_d.rrd_age = G1_L;
        if (cmd == CMD_MRS) st_d.mrd_age = G1_L;

        st_d.err_valid = (fin_err != ERR_NONE);
        st_d.err_code  = fin_err;
        if (pick_err != ERR_NONE && fin_err == pick_err)
            st_d.err_bank = pick_bank;
        else if (fin_err == ERR_BANK_OPEN)
            st_d.err_bank = open_bank;
        else if (fin_err == ERR_REFI)
            st_d.err_bank = '0;
        else
            st_d.err_bank = ba_i;

        if (fin_err != ERR_NONE) begin
            st_d.sticky = 1'b1;
            if (st_q.count != {CNT_W{1'b1}})
                st_d.count = st_q.count + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cke_prev  <= 1'b0;
            st_q.rrd_age   <= GAP_L;
            st_q.mrd_age   <= GAP_L;
            st_q.err_valid <= 1'b0;
            st_q.err_code  <= ERR_NONE;
            st_q.err_bank  <= '0;
            st_q.sticky    <= 1'b0;
            st_q.count     <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err_valid_o  = st_q.err_valid;
    assign err_code_o   = st_q.err_code;
    assign err_bank_o   = st_q.err_bank;
    assign err_sticky_o = st_q.sticky;
    assign err_count_o  = st_q.count;

    AST_STICKY_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_sticky_o |=> err_sticky_o); // R13

    AST_STROBE_SETS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_valid_o |-> err_sticky_o); // R13

    AST_REFRESH_WITH_OPEN_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((cmd == CMD_REF || cmd == CMD_SRE || cmd == CMD_MRS) && (|bank_open)) |=> err_valid_o); // R10

    AST_MRD_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(cmd == CMD_MRS) && cmd == CMD_ACT) |=> (err_valid_o && err_code_o == 4'd1)); // R8

endmodule

// File: tb/sdram_cmd_monitor_tb.sv
module sdram_cmd_monitor_tb;

    localparam int REFI = 2083;
    localparam logic [3:0] E_NOP = 4'b0111;
    localparam logic [3:0] E_ACT = 4'b0011;
    localparam logic [3:0] E_RD  = 4'b0101;
    localparam logic [3:0] E_WR  = 4'b0100;
    localparam logic [3:0] E_PRE = 4'b0010;
    localparam logic [3:0] E_BST = 4'b0110;
    localparam logic [3:0] E_REF = 4'b0001;
    localparam logic [3:0] E_MRS = 4'b0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1;
    logic        cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic        a10 = 1'b0;
    logic [1:0]  ba = 2'd0;
    logic        err_valid;
    logic [3:0]  err_code;
    logic [1:0]  err_bank;
    logic        err_sticky;
    logic [15:0] err_count;

    int tests = 0;
    int fails = 0;
    logic any_err;

    always #2 clk = ~clk;

    sdram_cmd_monitor u_dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .cke_i        (cke),
        .cs_ni        (cs_n),
        .ras_ni       (ras_n),
        .cas_ni       (cas_n),
        .we_ni        (we_n),
        .a10_i        (a10),
        .ba_i         (ba),
        .err_valid_o  (err_valid),
        .err_code_o   (err_code),
        .err_bank_o   (err_bank),
        .err_sticky_o (err_sticky),
        .err_count_o  (err_count)
    );

    // one command per cycle; outputs sampled just after the edge that registers the result
    task automatic drive(input logic [3:0] enc, input logic a10v, input logic [1:0] bav, input logic ckev);
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = enc;
        a10 = a10v;
        ba  = bav;
        cke = ckev;
        @(posedge clk);
        #1;
    endtask

    task automatic nop(input int n);
        for (int i = 0; i < n; i++) drive(E_NOP, 1'b0, 2'd0, 1'b1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        {cs_n, ras_n, cas_n, we_n} = E_NOP;
        cke = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        nop(2);
    endtask

    task automatic expect_err(input logic [3:0] code, input logic [1:0] bank, input string tag);
        tests++;
        if (code == 4'd0) begin
            if (err_valid !== 1'b0) begin
                fails++;
                $display("FAIL %s: valid=%0b code=%0d, expected no violation", tag, err_valid, err_code);
            end
        end else if (err_valid !== 1'b1 || err_code !== code || err_bank !== bank) begin
            fails++;
            $display("FAIL %s: valid=%0b code=%0d bank=%0d, expected valid=1 code=%0d bank=%0d",
                     tag, err_valid, err_code, err_bank, code, bank);
        end
    endtask

    task automatic expect_val(input int got, input int exp, input string tag);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic t_reset_idle();
        do_reset();
        expect_val(int'(err_valid), 0, "R13 reset strobe");
        expect_val(int'(err_sticky), 0, "R13 reset sticky");
        expect_val(int'(err_count), 0, "R13 reset count");
        any_err = 1'b0;
        for (int i = 0; i < 12; i++) begin
            drive(4'b1000 | 4'(i % 8), 1'(i % 2), 2'(i), 1'b1); // deselect, strobes varied
            any_err |= err_valid;
            nop(1);
            any_err |= err_valid;
        end
        expect_val(int'(any_err), 0, "R1 deselect and NOP stream raise nothing");
    endtask

    task automatic t_state();
        do_reset();
        drive(E_RD, 1'b0, 2'd1, 1'b1);  expect_err(4'd2, 2'd1, "R2 read closed bank");
        drive(E_WR, 1'b0, 2'd3, 1'b1);  expect_err(4'd2, 2'd3, "R2 write closed bank");
        drive(E_ACT, 1'b0, 2'd2, 1'b1); expect_err(4'd0, 2'd0, "R2 first activate");
        nop(8);
        drive(E_ACT, 1'b0, 2'd2, 1'b1); expect_err(4'd3, 2'd2, "R2 activate open bank");
    endtask

    task automatic t_trcd();
        do_reset();
        drive(E_ACT, 1'b0, 2'd0, 1'b1);
        nop(1);
        drive(E_RD, 1'b0, 2'd0, 1'b1);  expect_err(4'd5, 2'd0, "R3 read 2 after activate");
        drive(E_RD, 1'b0, 2'd0, 1'b1);  expect_err(4'd0, 2'd0, "R3 read 3 after activate");
        drive(E_BST, 1'b0, 2'd0, 1'b1); expect_err(4'd0, 2'd0, "R1 burst stop legal");
    endtask

    task automatic t_ras_rp_rc();
        do_reset();
        drive(E_ACT, 1'b0, 2'd1, 1'b1);
        nop(4);
        drive(E_PRE, 1'b0, 2'd1, 1'b1); expect_err(4'd7, 2'd1, "R5 precharge 5 after activate");
        nop(1);
        drive(E_ACT, 1'b0, 2'd1, 1'b1); expect_err(4'd6, 2'd1, "R4 activate 2 after precharge");
        do_reset();
        drive(E_ACT, 1'b0, 2'd1, 1'b1);
        nop(4);
        drive(E_PRE, 1'b0, 2'd1, 1'b1);
        nop(2);
        drive(E_ACT, 1'b0, 2'd1, 1'b1); expect_err(4'd8, 2'd1, "R6 same bank activate gap 8");
        do_reset();
        drive(E_ACT, 1'b0, 2'd3, 1'b1);
        nop(5);
        drive(E_PRE, 1'b0, 2'd3, 1'b1); expect_err(4'd0, 2'd0, "R5 precharge 6 after activate");
        nop(2);
        drive(E_ACT, 1'b0, 2'd3, 1'b1); expect_err(4'd0, 2'd0, "R4 R6 activate at limits");
    endtask

    task automatic t_rrd();
        do_reset();
        drive(E_ACT, 1'b0, 2'd0, 1'b1);
        drive(E_ACT, 1'b0, 2'd1, 1'b1); expect_err(4'd9, 2'd1, "R7 activates 1 apart");
        nop(1);
        drive(E_ACT, 1'b0, 2'd2, 1'b1); expect_err(4'd0, 2'd0, "R7 activates 2 apart");
    endtask

    task automatic t_mrd();
        do_reset();
        drive(E_MRS, 1'b0, 2'd0, 1'b1); expect_err(4'd0, 2'd0, "R8 mode set idle");
        drive(E_ACT, 1'b0, 2'd0, 1'b1); expect_err(4'd1, 2'd0, "R8 activate 1 after mode set");
        do_reset();
        drive(E_MRS, 1'b0, 2'd0, 1'b1);
        nop(1);
        drive(E_ACT, 1'b0, 2'd0, 1'b1); expect_err(4'd0, 2'd0, "R8 activate 2 after mode set");
        do_reset();
        drive(E_MRS, 1'b0, 2'd0, 1'b1);
        drive(E_RD, 1'b0, 2'd3, 1'b1);  expect_err(4'd1, 2'd3, "R13 priority mode window over closed read");
    endtask

    task automatic t_twr();
        do_reset();
        drive(E_ACT, 1'b0, 2'd0, 1'b1);
        nop(4);
        drive(E_WR, 1'b0, 2'd0, 1'b1);  expect_err(4'd0, 2'd0, "R9 write legal");
        drive(E_PRE, 1'b0, 2'd0, 1'b1); expect_err(4'd10, 2'd0, "R9 precharge 1 after data");
        do_reset();
        drive(E_ACT, 1'b0, 2'd0, 1'b1);
        nop(4);
        drive(E_WR, 1'b0, 2'd0, 1'b1);
        nop(1);
        drive(E_PRE, 1'b0, 2'd0, 1'b1); expect_err(4'd0, 2'd0, "R9 precharge 2 after data");
    endtask

    task automatic t_open_refresh();
        do_reset();
        drive(E_ACT, 1'b0, 2'd2, 1'b1);
        nop(2);
        drive(E_REF, 1'b0, 2'd0, 1'b1); expect_err(4'd4, 2'd2, "R10 refresh with bank open");
        do_reset();
        drive(E_ACT, 1'b0, 2'd1, 1'b1);
        nop(2);
        drive(E_MRS, 1'b0, 2'd0, 1'b1); expect_err(4'd4, 2'd1, "R10 mode set with bank open");
        do_reset();
        drive(E_ACT, 1'b0, 2'd0, 1'b1);
        nop(1);
        drive(E_ACT, 1'b0, 2'd3, 1'b1);
        nop(3);
        drive(E_PRE, 1'b1, 2'd0, 1'b1); expect_err(4'd7, 2'd3, "R5 all-bank precharge young bank");
        do_reset();
        drive(E_ACT, 1'b0, 2'd0, 1'b1);
        nop(1);
        drive(E_ACT, 1'b0, 2'd1, 1'b1);
        nop(5);
        drive(E_PRE, 1'b1, 2'd0, 1'b1); expect_err(4'd0, 2'd0, "R5 all-bank precharge legal");
        drive(E_REF, 1'b0, 2'd0, 1'b1); expect_err(4'd0, 2'd0, "R10 refresh after all closed");
    endtask

    task automatic t_autopre();
        do_reset();
        drive(E_ACT, 1'b0, 2'd0, 1'b1);
        nop(2);
        drive(E_WR, 1'b1, 2'd0, 1'b1);  expect_err(4'd0, 2'd0, "R12 write with auto-precharge");
        nop(2);
        drive(E_ACT, 1'b0, 2'd0, 1'b1); expect_err(4'd3, 2'd0, "R12 bank still open before close");
        do_reset();
        drive(E_ACT, 1'b0, 2'd0, 1'b1);
        nop(2);
        drive(E_WR, 1'b1, 2'd0, 1'b1);
        nop(4);
        drive(E_ACT, 1'b0, 2'd0, 1'b1); expect_err(4'd6, 2'd0, "R4 R12 activate 2 after auto close");
        do_reset();
        drive(E_ACT, 1'b0, 2'd0, 1'b1);
        nop(2);
        drive(E_WR, 1'b1, 2'd0, 1'b1);
        nop(5);
        drive(E_ACT, 1'b0, 2'd0, 1'b1); expect_err(4'd0, 2'd0, "R12 activate 3 after auto close");
        do_reset();
        drive(E_ACT, 1'b0, 2'd2, 1'b1);
        nop(2);
        drive(E_RD, 1'b1, 2'd2, 1'b1);
        nop(2);
        drive(E_REF, 1'b0, 2'd0, 1'b1); expect_err(4'd4, 2'd2, "R12 read auto-precharge not yet closed");
        do_reset();
        drive(E_ACT, 1'b0, 2'd2, 1'b1);
        nop(2);
        drive(E_RD, 1'b1, 2'd2, 1'b1);
        nop(3);
        drive(E_REF, 1'b0, 2'd0, 1'b1); expect_err(4'd0, 2'd0, "R12 read auto-precharge closed");
    endtask

    task automatic t_refresh_interval();
        do_reset();
        drive(E_REF, 1'b0, 2'd0, 1'b1);
        any_err = 1'b0;
        for (int k = 1; k < REFI; k++) begin
            nop(1);
            any_err |= err_valid;
        end
        expect_val(int'(any_err), 0, "R11 quiet before interval");
        nop(1);
        expect_err(4'd11, 2'd0, "R11 interval exceeded");
        nop(1);
        expect_err(4'd0, 2'd0, "R11 reported once");
        expect_val(int'(err_count), 1, "R13 count after one violation");
        expect_val(int'(err_sticky), 1, "R13 sticky held");
        do_reset();
        drive(E_REF, 1'b0, 2'd0, 1'b1);
        any_err = 1'b0;
        for (int k = 1; k < REFI; k++) begin
            nop(1);
            any_err |= err_valid;
        end
        drive(E_REF, 1'b0, 2'd0, 1'b1);
        any_err |= err_valid;
        nop(3);
        any_err |= err_valid;
        expect_val(int'(any_err), 0, "R11 refresh exactly at interval");
    endtask

    task automatic t_self_refresh();
        do_reset();
        drive(E_REF, 1'b0, 2'd0, 1'b0); expect_err(4'd0, 2'd0, "R1 self-refresh entry decoded");
        drive(E_RD, 1'b0, 2'd1, 1'b0);  expect_err(4'd0, 2'd1, "R1 command ignored with clock enable low");
        any_err = 1'b0;
        for (int k = 0; k < REFI + 200; k++) begin
            drive(E_NOP, 1'b0, 2'd0, 1'b0);
            any_err |= err_valid;
        end
        drive(E_NOP, 1'b0, 2'd0, 1'b1);
        any_err |= err_valid;
        for (int k = 0; k < 10; k++) begin
            nop(1);
            any_err |= err_valid;
        end
        expect_val(int'(any_err), 0, "R11 self refresh pauses watchdog");
    endtask

    task automatic t_count();
        do_reset();
        drive(E_RD, 1'b0, 2'd1, 1'b1);
        drive(E_RD, 1'b0, 2'd2, 1'b1);
        expect_val(int'(err_count), 2, "R13 count two violations");
        nop(1);
        expect_err(4'd0, 2'd0, "R13 strobe lasts one cycle");
        expect_val(int'(err_sticky), 1, "R13 sticky after quiet cycle");
        expect_val(int'(err_count), 2, "R13 count holds");
    endtask

    initial begin
        t_reset_idle();
        t_state();
        t_trcd();
        t_ras_rp_rc();
        t_rrd();
        t_mrd();
        t_twr();
        t_open_refresh();
        t_autopre();
        t_refresh_interval();
        t_self_refresh();
        t_count();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule